// File: doc/BRIEF.md
# Paged Slot Selector with Boot Override

This block maps the CPU's 64K address space onto four primary slots in 16K pages. Address bits 15:14 pick one of four pages, and an 8-bit page map register holds a 2-bit slot number for each page. The chosen slot number drives a 2-to-4 decoder. That decoder pulls exactly one active-low slot select low while a memory request is in progress.

After reset the page map register holds no trustworthy value, because the parallel port that normally loads it is back in input mode. A boot flag is set by reset to cover this. While the flag is set, the slot-number path is forced to zero, so every page reads from slot 0 and the boot ROM at address 0 can run. Writes to the page map register do not release the flag. Only a later control-port write with the release bit high releases it, so software can finish setting up the map first.

Top module: `paged_slot_select`

## Requirements
- R1: While `rst` is high at a clock edge, the page map register becomes 0x00 and the boot flag becomes set.
- R2: While the boot flag is set and `mem_req` is high, `slot_sel_n` is 4'b1110 (slot 0) for every page, whatever the page map register holds.
- R3: A page map write (`map_we` high) never releases the boot flag.
- R4: A control write (`ctl_we` high) with `ctl_din[REL_BIT]` high (default bit 4) releases the boot flag at that clock edge. A control write with that bit low leaves the flag unchanged.
- R5: Once the flag is released, the slot for page p = {addr_hi[1],addr_hi[0]} is map bits [2p+1:2p]. Page 0 uses bits 1:0 and page 3 uses bits 7:6.
- R6: While `mem_req` is low, all four `slot_sel_n` lines are high.
- R7: At most one `slot_sel_n` line is low at any time. With `mem_req` high, slot s drives line s low, so the output is ~(1<<s).
- R8: A reset during normal operation sets the flag again and clears the map. All pages return to slot 0 from the next cycle, until a new release.
- R9: A page map write takes `map_din` at the clock edge where `map_we` is high. The new mapping shows on `slot_sel_n` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 2 | CPU address bits 15:14 (page number) |
| mem_req | input | 1 | Memory request, active high |
| map_we | input | 1 | Page map register write strobe |
| map_din | input | 8 | Page map write data |
| ctl_we | input | 1 | Control port write strobe |
| ctl_din | input | 8 | Control port write data; bit REL_BIT releases the boot flag |
| slot_sel_n | output | 4 | Active-low primary slot selects |

## Verification
Register and flag updates take effect at the clock edge where their strobe is high. The select outputs are combinational from `addr_hi`, `mem_req` and that state, so each result is due in the same cycle, just after the edge. The bench drives strobes on the falling edge and removes them one nanosecond after the rising edge. It then changes the page and request inputs and samples one nanosecond later, before the next rising edge. This places every check within the single cycle that follows the write that caused it.

// File: rtl/slot_sel_pkg.sv
package slot_sel_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int NUM_PAGES = 4;
    localparam int PAGE_W    = $clog2(NUM_PAGES);
    localparam int MAP_W     = NUM_PAGES * SLOT_W;
    localparam int CTL_W     = 8;

    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [PAGE_W-1:0]    page_t;
    typedef logic [MAP_W-1:0]     map_t;
    typedef logic [NUM_SLOTS-1:0] sel_t;

    // Resolved slot request passed from the mux to the decoder
    typedef struct packed {
        logic  active;
        slot_t slot;
    } slot_req_t;

    function automatic slot_t field_of(input map_t m, input page_t p);
        return m[p*SLOT_W +: SLOT_W];
    endfunction

endpackage

// File: rtl/page_map_reg.sv
module page_map_reg
    import slot_sel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  map_t din,
    output map_t map_q
);

    always_ff @(posedge clk) begin
        if (rst)
            map_q <= '0;
        else if (we)
            map_q <= din;
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> map_q == '0);

    p_write_take_r9: assert property (@(posedge clk) disable iff (rst)
        we |=> map_q == $past(din));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(map_q));

endmodule

// File: rtl/boot_hold.sv
module boot_hold
    import slot_sel_pkg::*;
#(
    parameter int REL_BIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_din,
    output logic             boot_q
);

    logic release_hit;
    assign release_hit = ctl_we && ctl_din[REL_BIT];

    // Set by reset, cleared only by the release bit
    always_ff @(posedge clk) begin
        if (rst)
            boot_q <= 1'b1;
        else if (release_hit)
            boot_q <= 1'b0;
    end

    p_reset_set_r1: assert property (@(posedge clk) rst |=> boot_q);

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_din[REL_BIT]) |=> !boot_q);

    p_hold_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (boot_q && !(ctl_we && ctl_din[REL_BIT])) |=> boot_q);

    p_no_reassert_r4: assert property (@(posedge clk) disable iff (rst)
        !boot_q |=> !boot_q);

endmodule

// File: rtl/slot_mux.sv
module slot_mux
    import slot_sel_pkg::*;
(
    input  map_t      map_q,
    input  page_t     page,
    input  logic      boot,
    input  logic      mem_req,
    output slot_req_t req
);

    slot_t fields [NUM_PAGES];

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PAGES; gp++) begin : g_field
            assign fields[gp] = field_of(map_q, page_t'(gp));
        end
    endgenerate

    // Boot flag disables the mux: the slot number reads as zero
    always_comb begin
        req.active = mem_req;
        req.slot   = boot ? '0 : fields[page];
    end

    always_comb begin
        if (boot) a_boot_slot0_r2: assert (req.slot == '0);
    end

endmodule

// File: rtl/slot_decoder.sv
module slot_decoder
    import slot_sel_pkg::*;
(
    input  slot_req_t req,
    output sel_t      sel_n
);

    genvar gs;
    generate
        for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_line
            assign sel_n[gs] = !(req.active && (req.slot == slot_t'(gs)));
        end
    endgenerate

endmodule

// File: rtl/paged_slot_select.sv
module paged_slot_select
    import slot_sel_pkg::*;
#(
    parameter int REL_BIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PAGE_W-1:0] addr_hi,
    input  logic             mem_req,
    input  logic             map_we,
    input  logic [MAP_W-1:0] map_din,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_din,
    output logic [NUM_SLOTS-1:0] slot_sel_n
);

    map_t      map_q;
    logic      boot_q;
    slot_req_t req;

    page_map_reg i_map (
        .clk   (clk),
        .rst   (rst),
        .we    (map_we),
        .din   (map_din),
        .map_q (map_q)
    );

    boot_hold #(.REL_BIT(REL_BIT)) i_boot (
        .clk     (clk),
        .rst     (rst),
        .ctl_we  (ctl_we),
        .ctl_din (ctl_din),
        .boot_q  (boot_q)
    );

    slot_mux i_mux (
        .map_q   (map_q),
        .page    (addr_hi),
        .boot    (boot_q),
        .mem_req (mem_req),
        .req     (req)
    );

    slot_decoder i_dec (
        .req   (req),
        .sel_n (slot_sel_n)
    );

    p_idle_high_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> slot_sel_n == '1);

    p_one_low_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~slot_sel_n));

    p_req_low_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> $countones(~slot_sel_n) == 1);

    p_boot_page_r2: assert property (@(posedge clk) disable iff (rst)
        (boot_q && mem_req) |-> slot_sel_n == 4'b1110);

    p_reset_slot0_r8: assert property (@(posedge clk)
        (rst && !map_we && !ctl_we) |=> (mem_req |-> slot_sel_n == 4'b1110));

endmodule

// File: tb/test_paged_slot_select.sv
module test_paged_slot_select;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr_hi = '0;
    logic       mem_req = 1'b0;
    logic       map_we = 1'b0;
    logic [7:0] map_din = '0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_din = '0;
    logic [3:0] slot_sel_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    paged_slot_select i_paged_slot_select (
        .clk        (clk),
        .rst        (rst),
        .addr_hi    (addr_hi),
        .mem_req    (mem_req),
        .map_we     (map_we),
        .map_din    (map_din),
        .ctl_we     (ctl_we),
        .ctl_din    (ctl_din),
        .slot_sel_n (slot_sel_n)
    );

    function automatic logic [3:0] expect_sel(input logic [7:0] m, input int page,
                                              input logic req, input logic boot);
        int s;
        s = boot ? 0 : int'((m >> (2 * page)) & 8'h3);
        return req ? ~(4'b0001 << s) : 4'b1111;
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic probe(input string tag, input int page, input logic req,
                         input logic [7:0] m, input logic boot);
        addr_hi = page[1:0];
        mem_req = req;
        #1;
        chk(tag, slot_sel_n, expect_sel(m, page, req, boot));
        chk({tag, "/R7"}, {3'b0, $countones(~slot_sel_n) <= 1}, 4'd1);
    endtask

    task automatic write_map(input logic [7:0] v);
        @(negedge clk);
        map_we = 1'b1; map_din = v;
        @(posedge clk); #1;
        map_we = 1'b0;
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_din = v;
        @(posedge clk); #1;
        ctl_we = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R6: reset state
        for (int p = 0; p < 4; p++) begin
            probe("R1 reset slot0", p, 1'b1, 8'h00, 1'b1);
            probe("R6 idle after reset", p, 1'b0, 8'h00, 1'b1);
        end

        // R2 / R3: map writes during boot change nothing, flag held
        for (int v = 0; v < 256; v++) begin
            write_map(v[7:0]);
            for (int p = 0; p < 4; p++)
                probe("R2 R3 boot forces slot0", p, 1'b1, v[7:0], 1'b1);
        end

        // R4: control write without release bit has no effect
        write_ctl(8'hEF);
        for (int p = 0; p < 4; p++)
            probe("R4 no release on bit low", p, 1'b1, 8'hFF, 1'b1);

        // R4 / R5: release, map 0xE4 gives page p -> slot p
        write_map(8'hE4);
        probe("R2 still boot before release", 3, 1'b1, 8'hE4, 1'b1);
        write_ctl(8'h10);
        for (int p = 0; p < 4; p++)
            probe("R4 R5 release identity map", p, 1'b1, 8'hE4, 1'b0);

        // R5 / R6 / R7 / R9: full sweep after release
        for (int v = 0; v < 256; v++) begin
            write_map(v[7:0]);
            for (int p = 0; p < 4; p++) begin
                probe("R5 R9 mapped slot", p, 1'b1, v[7:0], 1'b0);
                probe("R6 idle mapped", p, 1'b0, v[7:0], 1'b0);
            end
        end

        // R4: further control writes keep the flag released
        write_ctl(8'h00);
        probe("R4 stays released", 0, 1'b1, 8'hFF, 1'b0);

        // R8: reset during operation
        write_map(8'h1B);
        probe("R8 pre-reset map", 0, 1'b1, 8'h1B, 1'b0);
        pulse_reset();
        for (int p = 0; p < 4; p++)
            probe("R8 reset returns slot0", p, 1'b1, 8'h00, 1'b1);
        write_map(8'h93);
        for (int p = 0; p < 4; p++)
            probe("R8 R3 boot after re-reset", p, 1'b1, 8'h93, 1'b1);
        write_ctl(8'h10);
        for (int p = 0; p < 4; p++)
            probe("R8 new map after release", p, 1'b1, 8'h93, 1'b0);

        // R8 / R1: map cleared by reset
        pulse_reset();
        write_ctl(8'hFF);
        for (int p = 0; p < 4; p++)
            probe("R1 R8 map cleared", p, 1'b1, 8'h00, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule